// File: doc/BRIEF.md
# Register-Pair Add and Multiply-Accumulate Unit

This execution unit carries out a family of double-word arithmetic instructions. The accumulator for these instructions lives in a pair of general-purpose registers. The unit receives a 32-bit instruction word, the values of the four register operands it names (destination-high, destination-low, source-B and source-C), and the current carry flag. It returns a 64-bit result for write-back to the destination pair. It also returns a new carry flag and a new overflow flag, each with its own write enable.

A four-bit sub-opcode selects the operation:

- Plain add or subtract of the 64-bit value formed from source-B and source-C.
- Add with carry, or subtract with borrow. These let long additions be chained two words at a time.
- A signed or unsigned 32x32 multiply of source-B by source-C. The product can replace the pair, be added to it, or be subtracted from it.

Both flags always come from the final 64-bit addition, whatever the signedness of the multiply. Two suppress bits in the instruction word can withhold either flag write.

The unit accepts one operation per cycle when `start_i` is high. It presents the registered result one cycle later, with a single-cycle `valid_o` pulse. Encodings it does not recognise raise `illegal_o` in place of `valid_o`.

Top module: `pacc_unit`

## Requirements
- R1: Instruction fields are decoded as follows. Bits 31:26 must equal 0x14. Bit 5 suppresses the overflow write when it is 1. Bit 4 suppresses the carry write when it is 1. Bits 3:0 hold the sub-opcode. Bits 25:6 are register numbers and have no effect on the unit.
- R2: Sub-opcodes 0000, 0001, 0010 and 0011 form the result from the accumulator pair A = rd:ra and the operand P = rb:rc (rb is the upper word). The results are, in order: A+P; A+~P+1; A+P+cy_i; and A+~P+(not cy_i).
- R3: Sub-opcodes 0100 (signed) and 0101 (unsigned) return the 64-bit product of rb and rc. Each operand is sign-extended or zero-extended according to that choice.
- R4: Sub-opcodes 0110 (signed) and 0111 (unsigned) return A plus the product. Sub-opcodes 1000 (signed) and 1001 (unsigned) return A+~prod+1.
- R5: `result_o[63:32]` carries the value for rd and `result_o[31:0]` carries the value for ra.
- R6: `cy_o` is the carry-out of the 64-bit addition. It is inverted for the subtracting sub-opcodes 0001, 0011, 1000 and 1001.
- R7: `ov_o` is 1 exactly when the two 64-bit addends (the accumulator term and the possibly inverted P) share a sign bit and the sum's sign bit differs from it. This holds for signed and unsigned multiplies alike.
- R8: For a legal operation, `cy_we_o` equals the inverse of bit 4 and `ov_we_o` equals the inverse of bit 5.
- R9: A major opcode other than 0x14, or a sub-opcode from 1010 to 1111, gives `illegal_o` = 1 in the next cycle. In that case `valid_o`, `cy_we_o` and `ov_we_o` are all 0.
- R10: `valid_o` pulses for exactly the one cycle after a legal operation is accepted. Without `start_i`, `valid_o`, `illegal_o` and both write enables are 0 in the next cycle.
- R11: Synchronous active-low reset clears `valid_o`, `illegal_o`, both write enables, both flags and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Accept an operation this cycle |
| insn_i | input | 32 | Instruction word |
| rd_val_i | input | 32 | Value of the high accumulator register |
| ra_val_i | input | 32 | Value of the low accumulator register |
| rb_val_i | input | 32 | Source-B value |
| rc_val_i | input | 32 | Source-C value |
| cy_i | input | 1 | Current carry flag |
| valid_o | output | 1 | Result and flags are valid |
| illegal_o | output | 1 | Accepted instruction was not recognised |
| result_o | output | 64 | Result: high word for rd, low word for ra |
| cy_o | output | 1 | New carry flag |
| cy_we_o | output | 1 | Carry flag write enable |
| ov_o | output | 1 | New overflow flag |
| ov_we_o | output | 1 | Overflow flag write enable |

## Verification
A wrong decode entry would show up in the very next cycle after the offending operation. It would appear as a result off by the product, by a complement, or by one. It could also appear as a carry of the wrong polarity, or as a valid pulse where `illegal_o` belonged. Because every output register is loaded from a single accepted operation, no error can hide and surface later. The bench sweeps all sixteen sub-opcodes against every suppress-bit and carry-in combination over boundary operands (zero, one, the most negative value, all-ones). It then runs a random pass, so that sign-extension and overflow mistakes surface at once.

// File: rtl/pacc_pkg.sv
// Package: shared constants and decoded-control type for the register-pair
// arithmetic unit. Assumes the fixed 32-bit instruction layout.
package pacc_pkg;

    localparam int unsigned INSN_W   = 32;
    localparam logic [5:0]  MAJOR_OP = 6'h14;

    // Source of the carry into the 64-bit adder
    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_FLAG  = 2'd2,
        CIN_NFLAG = 2'd3
    } cin_sel_e;

    typedef struct packed {
        logic     illegal;
        logic     use_acc;
        logic     use_mul;
        logic     mul_signed;
        cin_sel_e cin_sel;
        logic     invert;
        logic     keep_cy;
        logic     keep_ov;
    } pacc_ctrl_t;

endpackage

// File: rtl/pacc_decode.sv
// Decoder: turns the instruction word into adder/multiplier controls.
// Assumes the layout major[31:26], suppress-ov[5], suppress-cy[4], sub[3:0];
// register-number fields are ignored here.
module pacc_decode
    import pacc_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output pacc_ctrl_t        ctrl_o
);

    logic [3:0] sub_op;
    assign sub_op = insn_i[3:0];

    // Map the sub-opcode to controls and flag the encodings with no meaning
    always_comb begin
        ctrl_o            = '0;
        ctrl_o.cin_sel    = CIN_ZERO;
        ctrl_o.keep_cy    = ~insn_i[4];
        ctrl_o.keep_ov    = ~insn_i[5];
        unique case (sub_op)
            4'b0000: begin ctrl_o.use_acc = 1'b1; end
            4'b0001: begin ctrl_o.use_acc = 1'b1; ctrl_o.cin_sel = CIN_ONE;   ctrl_o.invert = 1'b1; end
            4'b0010: begin ctrl_o.use_acc = 1'b1; ctrl_o.cin_sel = CIN_FLAG; end
            4'b0011: begin ctrl_o.use_acc = 1'b1; ctrl_o.cin_sel = CIN_NFLAG; ctrl_o.invert = 1'b1; end
            4'b0100: begin ctrl_o.use_mul = 1'b1; ctrl_o.mul_signed = 1'b1; end
            4'b0101: begin ctrl_o.use_mul = 1'b1; end
            4'b0110: begin ctrl_o.use_acc = 1'b1; ctrl_o.use_mul = 1'b1; ctrl_o.mul_signed = 1'b1; end
            4'b0111: begin ctrl_o.use_acc = 1'b1; ctrl_o.use_mul = 1'b1; end
            4'b1000: begin ctrl_o.use_acc = 1'b1; ctrl_o.use_mul = 1'b1; ctrl_o.mul_signed = 1'b1;
                           ctrl_o.cin_sel = CIN_ONE; ctrl_o.invert = 1'b1; end
            4'b1001: begin ctrl_o.use_acc = 1'b1; ctrl_o.use_mul = 1'b1;
                           ctrl_o.cin_sel = CIN_ONE; ctrl_o.invert = 1'b1; end
            default: begin ctrl_o.illegal = 1'b1; end
        endcase
        if (insn_i[31:26] != MAJOR_OP) begin
            ctrl_o.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/pacc_mul.sv
// Multiplier: full-width product of two XLEN-bit words, with each operand
// sign- or zero-extended by one control. Purely combinational.
module pacc_mul #(
    parameter int unsigned XLEN = 32
) (
    input  logic              is_signed_i,
    input  logic [XLEN-1:0]   x_i,
    input  logic [XLEN-1:0]   y_i,
    output logic [2*XLEN-1:0] prod_o
);

    localparam int unsigned EXT_W  = XLEN + 1;
    localparam int unsigned FULL_W = 2 * EXT_W;

    logic signed [EXT_W-1:0]  x_ext;
    logic signed [EXT_W-1:0]  y_ext;
    logic signed [FULL_W-1:0] full;

    // Extend both operands by one bit so a single signed multiplier serves both modes
    always_comb begin
        x_ext  = {is_signed_i & x_i[XLEN-1], x_i};
        y_ext  = {is_signed_i & y_i[XLEN-1], y_i};
        full   = FULL_W'(x_ext) * FULL_W'(y_ext);
        prod_o = full[2*XLEN-1:0];
    end

endmodule

// File: rtl/pacc_adder.sv
// Adder: acc + (invert ? ~p : p) + cin over DLEN bits, returning the sum,
// the raw carry-out and the signed-overflow indication of that addition.
module pacc_adder #(
    parameter int unsigned DLEN = 64
) (
    input  logic [DLEN-1:0] acc_i,
    input  logic [DLEN-1:0] p_i,
    input  logic            invert_i,
    input  logic            cin_i,
    output logic [DLEN-1:0] sum_o,
    output logic            carry_o,
    output logic            ovf_o
);

    logic [DLEN-1:0] addend;
    logic [DLEN:0]   wide;

    // Form the second addend and the carry-extended sum
    always_comb begin
        addend  = invert_i ? ~p_i : p_i;
        wide    = {1'b0, acc_i} + {1'b0, addend} + {{DLEN{1'b0}}, cin_i};
        sum_o   = wide[DLEN-1:0];
        carry_o = wide[DLEN];
        ovf_o   = (acc_i[DLEN-1] == addend[DLEN-1]) && (wide[DLEN-1] != acc_i[DLEN-1]);
    end

endmodule

// File: rtl/pacc_unit.sv
// Top: register-pair add / multiply-accumulate unit. Decodes the instruction,
// forms the operand (product or rb:rc), adds it to the pair or zero, and
// registers result, flags and enables one cycle after start_i.
// Assumes the register file supplies operands in the start cycle.
module pacc_unit
    import pacc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic [XLEN-1:0]     rd_val_i,
    input  logic [XLEN-1:0]     ra_val_i,
    input  logic [XLEN-1:0]     rb_val_i,
    input  logic [XLEN-1:0]     rc_val_i,
    input  logic                cy_i,
    output logic                valid_o,
    output logic                illegal_o,
    output logic [2*XLEN-1:0]   result_o,
    output logic                cy_o,
    output logic                cy_we_o,
    output logic                ov_o,
    output logic                ov_we_o
);

    localparam int unsigned DLEN = 2 * XLEN;

    pacc_ctrl_t      ctrl;
    logic [DLEN-1:0] prod;
    logic [DLEN-1:0] p_opnd;
    logic [DLEN-1:0] acc_term;
    logic            cin;
    logic [DLEN-1:0] sum;
    logic            carry_raw;
    logic            ovf;

    pacc_decode u_dec (
        .insn_i (insn_i),
        .ctrl_o (ctrl)
    );

    pacc_mul #(.XLEN(XLEN)) u_mul (
        .is_signed_i (ctrl.mul_signed),
        .x_i         (rb_val_i),
        .y_i         (rc_val_i),
        .prod_o      (prod)
    );

    // Choose the operand, accumulator term and carry-in from the decoded controls
    always_comb begin
        p_opnd   = ctrl.use_mul ? prod : {rb_val_i, rc_val_i};
        acc_term = ctrl.use_acc ? {rd_val_i, ra_val_i} : '0;
        unique case (ctrl.cin_sel)
            CIN_ONE:   cin = 1'b1;
            CIN_FLAG:  cin = cy_i;
            CIN_NFLAG: cin = ~cy_i;
            default:   cin = 1'b0;
        endcase
    end

    pacc_adder #(.DLEN(DLEN)) u_add (
        .acc_i    (acc_term),
        .p_i      (p_opnd),
        .invert_i (ctrl.invert),
        .cin_i    (cin),
        .sum_o    (sum),
        .carry_o  (carry_raw),
        .ovf_o    (ovf)
    );

    // Output registers: capture on start, pulse-type strobes clear otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            illegal_o <= 1'b0;
            cy_we_o   <= 1'b0;
            ov_we_o   <= 1'b0;
            cy_o      <= 1'b0;
            ov_o      <= 1'b0;
            result_o  <= '0;
        end else begin
            valid_o   <= start_i & ~ctrl.illegal;
            illegal_o <= start_i &  ctrl.illegal;
            cy_we_o   <= start_i & ~ctrl.illegal & ctrl.keep_cy;
            ov_we_o   <= start_i & ~ctrl.illegal & ctrl.keep_ov;
            if (start_i) begin
                result_o <= sum;
                cy_o     <= carry_raw ^ ctrl.invert;
                ov_o     <= ovf;
            end
        end
    end

    // R9: an illegal operation never produces valid or flag writes
    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!valid_o && !cy_we_o && !ov_we_o));

    // R10: a legal accepted operation yields valid in the next cycle
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ctrl.illegal) |=> valid_o);

    // R10: no start means no strobes next cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!valid_o && !illegal_o && !cy_we_o && !ov_we_o));

    // R8: carry-suppress bit blocks the carry write
    a_r8_cy_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[4]) |=> !cy_we_o);

    // R8: overflow-suppress bit blocks the overflow write
    a_r8_ov_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && insn_i[5]) |=> !ov_we_o);

    // R10: write enables only accompany a valid result
    a_r10_we_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_we_o || ov_we_o) |-> valid_o);

endmodule

// File: tb/pacc_unit_tb_top.sv
// Bench: sweeps every sub-opcode, suppress combination and carry-in over
// boundary operands, then random operands; expected values are computed
// arithmetically from the requirements.
module pacc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [31:0] rd_val_i = '0, ra_val_i = '0, rb_val_i = '0, rc_val_i = '0;
    logic        cy_i = 1'b0;
    logic        valid_o, illegal_o, cy_o, cy_we_o, ov_o, ov_we_o;
    logic [63:0] result_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pacc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .rd_val_i(rd_val_i), .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .rc_val_i(rc_val_i),
        .cy_i(cy_i), .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o),
        .cy_o(cy_o), .cy_we_o(cy_we_o), .ov_o(ov_o), .ov_we_o(ov_we_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One operation: drive at negedge, outputs registered at next posedge, sample at following negedge
    task automatic run_op(input logic [5:0] major, input logic sov, input logic scy, input logic [3:0] sub,
                          input logic [31:0] rd, input logic [31:0] ra, input logic [31:0] rb,
                          input logic [31:0] rc, input logic cy);
        logic        legal, mul, sgn, accu, inv, cin;
        logic [63:0] a, p, addend, exp_sum;
        logic [64:0] wide;
        logic        exp_cy, exp_ov;
        legal = (major == 6'h14) && (sub <= 4'd9);
        mul   = (sub >= 4'd4) && (sub <= 4'd9);
        sgn   = mul && !sub[0];
        accu  = !(sub == 4'd4 || sub == 4'd5);
        inv   = (sub == 4'd1) || (sub == 4'd3) || (sub == 4'd8) || (sub == 4'd9);
        case (sub)
            4'd1, 4'd8, 4'd9: cin = 1'b1;
            4'd2:             cin = cy;
            4'd3:             cin = ~cy;
            default:          cin = 1'b0;
        endcase
        a = accu ? {rd, ra} : 64'd0;
        if (mul) begin
            if (sgn) p = 64'($signed({{32{rb[31]}}, rb}) * $signed({{32{rc[31]}}, rc}));
            else     p = {32'd0, rb} * {32'd0, rc};
        end else begin
            p = {rb, rc};
        end
        addend  = inv ? ~p : p;
        wide    = {1'b0, a} + {1'b0, addend} + {64'd0, cin};
        exp_sum = wide[63:0];
        exp_cy  = wide[64] ^ inv;
        exp_ov  = (a[63] == addend[63]) && (exp_sum[63] != a[63]);

        @(negedge clk);
        start_i  = 1'b1;
        insn_i   = {major, 5'd3, 5'd4, 5'd5, 5'd6, sov, scy, sub};
        rd_val_i = rd; ra_val_i = ra; rb_val_i = rb; rc_val_i = rc; cy_i = cy;
        @(negedge clk);
        start_i = 1'b0;
        if (legal) begin
            chk(mul ? (accu ? "R4 result" : "R3 result") : "R2 result", result_o, exp_sum);
            chk("R5 high word", {32'd0, result_o[63:32]}, {32'd0, exp_sum[63:32]});
            chk("R6 carry", {63'd0, cy_o}, {63'd0, exp_cy});
            chk("R7 overflow", {63'd0, ov_o}, {63'd0, exp_ov});
            chk("R8 cy_we", {63'd0, cy_we_o}, {63'd0, ~scy});
            chk("R8 ov_we", {63'd0, ov_we_o}, {63'd0, ~sov});
            chk("R10 valid", {63'd0, valid_o}, 64'd1);
            chk("R9 no illegal", {63'd0, illegal_o}, 64'd0);
        end else begin
            chk("R9 illegal", {63'd0, illegal_o}, 64'd1);
            chk("R9 no valid", {63'd0, valid_o}, 64'd0);
            chk("R9 no we", {62'd0, cy_we_o, ov_we_o}, 64'd0);
        end
        @(negedge clk);
        chk("R10 single pulse", {60'd0, valid_o, illegal_o, cy_we_o, ov_we_o}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        logic [31:0] tbl [4];
        tbl[0] = 32'h0000_0000; tbl[1] = 32'h0000_0001;
        tbl[2] = 32'h8000_0000; tbl[3] = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 reset strobes", {60'd0, valid_o, illegal_o, cy_we_o, ov_we_o}, 64'd0);
        chk("R11 reset result", result_o, 64'd0);
        chk("R11 reset flags", {62'd0, cy_o, ov_o}, 64'd0);
        rst_n = 1'b1;
        // R1 R2 R3 R4: sweep sub-opcodes, suppress bits, carry-in, boundary operands
        for (int s = 0; s < 16; s++)
            for (int f = 0; f < 8; f++)
                for (int k = 0; k < 256; k++)
                    if ((s < 10) || (k < 4))
                        run_op(6'h14, f[2], f[1], s[3:0], tbl[k[1:0]], tbl[k[3:2]],
                               tbl[k[5:4]], tbl[k[7:6]], f[0]);
        // R9: wrong major opcode with otherwise legal sub-opcodes
        for (int s = 0; s < 10; s++)
            run_op(6'h15, 1'b0, 1'b0, s[3:0], 32'd1, 32'd2, 32'd3, 32'd4, 1'b0);
        // R7: random operands across all legal sub-opcodes
        for (int i = 0; i < 3000; i++)
            run_op(6'h14, 1'($urandom), 1'($urandom), 4'($urandom_range(0, 9)),
                   $urandom, $urandom, $urandom, $urandom, 1'($urandom));
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule